// File: doc/BRIEF.md
# Autoscan ADC Conversion Sequencer

This block is the digital control side of a multi-channel successive-approximation converter. It walks the converter through a group of channels. The walk begins at a programmable first channel and ends at the highest channel. Each channel gets a sample phase and then a conversion phase. The length of both phases scales with a programmable clock division factor. The converter's result is stored in a per-channel result register. When the last channel completes, a sticky end-of-scan flag is set, and a maskable interrupt request is driven from it.

A scan is started by a start bit. Software can set that bit with a one-cycle pulse. An enabled hardware trigger can also set it: either an external pin or an internal timer line, both active low. In single mode, one group of conversions runs per start event, and the start bit then drops. In continuous mode, the group repeats from the first channel with no idle cycle between groups, until software clears the start bit. A power-down input forces the block idle.

The converter side has no back-pressure. The converter must present its result on `conv_result` by the last conversion cycle, and that bus is sampled in that cycle. The results are read through a plain combinational select port.

Top module: `adc_scan_seq`

## Requirements
- R1: During a scan, `conv_ch` steps by exactly one when each channel's conversion completes. It goes from the first channel up to channel CH_N-1 (7 by default).
- R2: A scan begins with `conv_ch` equal to `cfg_first_ch`. A first channel of 7 converts only channel 7.
- R3: A `sw_start_set` pulse sets `start_bit` at the next rising edge, and `busy` with the sample phase follows one edge later. `busy` is never high while `start_bit` is low.
- R4: In single mode (`cfg_cont`=0), the edge that completes channel 7 clears `start_bit` and `busy` together. A `sw_start_clr` pulse clears both at the next edge in either mode, and that channel's result is discarded.
- R5: In continuous mode (`cfg_cont`=1), the edge that completes channel 7 starts the sample phase of the first channel. `start_bit` stays set.
- R6: On the edge that ends a channel's conversion phase, the value on `conv_result` is written into that channel's register, replacing the old value. `rd_data` shows the register picked by `rd_sel`, and all registers reset to zero.
- R7: Each trigger input is synchronised by two flops and acts on a falling edge. The trigger counts only when its enable is set (`cfg_ext_en` for the pin, `cfg_tim_en` for the timer). A low pulse of one clock cycle sets `start_bit` on the third rising edge after the input goes low. A trigger whose enable is clear has no effect.
- R8: A trigger that arrives while `start_bit` is set has no effect, so a running scan is neither restarted nor moved to another channel.
- R9: The sample phase (`conv_sample`) lasts 84×FDF cycles and the conversion phase (`conv_convert`) lasts 54×FDF cycles, so one channel takes 138×FDF cycles. `cfg_prsc` codes 0..7 give FDF = 1, 2, 4, 6, 8, 10, 12, 16. The two phase outputs are never high together.
- R10: While `cfg_pdown` is high, `start_bit` and `busy` are low from the next edge on, and no start request takes effect.
- R11: `eoc_flag` is set on every completion of channel 7, in both modes. It stays set until an `eoc_clr` pulse; a completion in the same cycle as the pulse wins. `eoc_irq` equals `eoc_flag` AND `cfg_eoc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cont | input | 1 | 1 = continuous scanning, 0 = one group per start |
| cfg_first_ch | input | CH_W | First channel of each group |
| cfg_prsc | input | 3 | Division factor code |
| cfg_pdown | input | 1 | Power-down: hold idle |
| cfg_ext_en | input | 1 | Enable for the external trigger pin |
| cfg_tim_en | input | 1 | Enable for the internal timer trigger |
| cfg_eoc_en | input | 1 | Interrupt mask for the end-of-scan flag |
| sw_start_set | input | 1 | Software pulse that sets the start bit |
| sw_start_clr | input | 1 | Software pulse that clears the start bit and stops the scan |
| eoc_clr | input | 1 | Software pulse that clears the end-of-scan flag |
| ext_trig_n | input | 1 | External trigger, active low |
| tim_trig_n | input | 1 | Timer trigger, active low |
| conv_result | input | RES_W | Converter result bus |
| conv_ch | output | CH_W | Channel being sampled or converted |
| conv_sample | output | 1 | Sample phase active |
| conv_convert | output | 1 | Conversion phase active |
| busy | output | 1 | A channel is in progress |
| start_bit | output | 1 | Start bit state |
| eoc_flag | output | 1 | Pending end-of-scan flag |
| eoc_irq | output | 1 | Masked interrupt request |
| rd_sel | input | CH_W | Result register select |
| rd_data | output | RES_W | Selected result register |

## Verification
After a start pulse, `start_bit` is due one edge later. `busy` and the first channel's sample phase are due two edges later. After that, every event is fixed by the division factor:
- the sample-to-convert switch comes 84×FDF edges after the first channel starts;
- each result write comes at a multiple of 138×FDF edges;
- the end-of-scan flag comes (8−first)×138×FDF edges after the first channel starts.

For the triggers, the bench allows three edges after the pin goes low. The bench computes each of these edge counts from the configuration it chose. It waits that exact number of falling clock edges, and it checks both the cycle before a change and the cycle after it. That way, an early or late transition by one cycle is caught.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_CONVERT = 2'd2
  } phase_t;

  // Division factor for each prescaler code
  function automatic logic [4:0] fdf_of(input logic [2:0] code);
    logic [4:0] f;
    case (code)
      3'd0:    f = 5'd1;
      3'd1:    f = 5'd2;
      3'd2:    f = 5'd4;
      3'd3:    f = 5'd6;
      3'd4:    f = 5'd8;
      3'd5:    f = 5'd10;
      3'd6:    f = 5'd12;
      default: f = 5'd16;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] trig_n,
  input  logic [N_SRC-1:0] src_en,
  output logic             evt
);

  logic [N_SRC-1:0] hit;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b1;
          sync_q <= 1'b1;
          prev_q <= 1'b1;
        end else begin
          meta_q <= trig_n[g];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      // falling edge of the synchronised level
      assign hit[g] = src_en[g] & prev_q & ~sync_q;
    end
  endgenerate

  assign evt = |hit;

endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int CH_N  = 8,
  parameter int RES_W = 10,
  localparam int CH_W = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data
);

  logic [RES_W-1:0] bank [CH_N];

  generate
    for (genvar c = 0; c < CH_N; c++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                bank[c] <= '0;
        else if (wr_en && (wr_ch == CH_W'(c)))     bank[c] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = bank[rd_ch];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH_N         = 8,
  parameter int RES_W        = 10,
  parameter int SAMPLE_UNITS = 84,
  parameter int HOLD_UNITS   = 54,
  parameter int FDF_MAX      = 16,
  localparam int CH_W        = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cont,
  input  logic [CH_W-1:0]  cfg_first_ch,
  input  logic [2:0]       cfg_prsc,
  input  logic             cfg_pdown,
  input  logic             cfg_ext_en,
  input  logic             cfg_tim_en,
  input  logic             cfg_eoc_en,
  input  logic             sw_start_set,
  input  logic             sw_start_clr,
  input  logic             eoc_clr,
  input  logic             ext_trig_n,
  input  logic             tim_trig_n,
  input  logic [RES_W-1:0] conv_result,
  output logic [CH_W-1:0]  conv_ch,
  output logic             conv_sample,
  output logic             conv_convert,
  output logic             busy,
  output logic             start_bit,
  output logic             eoc_flag,
  output logic             eoc_irq,
  input  logic [CH_W-1:0]  rd_sel,
  output logic [RES_W-1:0] rd_data
);

  localparam int CNT_W = $clog2((SAMPLE_UNITS + HOLD_UNITS) * FDF_MAX + 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(CH_N - 1);
  localparam logic [CNT_W-1:0] SMP_U    = CNT_W'(SAMPLE_UNITS);
  localparam logic [CNT_W-1:0] HLD_U    = CNT_W'(HOLD_UNITS);

  phase_t            phase_q;
  logic [CH_W-1:0]   ch_q;
  logic              start_q;
  logic              eoc_q;

  logic              trig_evt;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_done;
  logic              abort;
  logic              ch_done;
  logic              at_last;
  logic              wrap;
  logic [CNT_W-1:0]  fdf_w;
  logic [CNT_W-1:0]  sample_len;
  logic [CNT_W-1:0]  hold_len;

  // Trigger sources: bit 0 external pin, bit 1 timer line
  adc_trig_detect #(.N_SRC(2)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_n ({tim_trig_n, ext_trig_n}),
    .src_en ({cfg_tim_en, cfg_ext_en}),
    .evt    (trig_evt)
  );

  // Phase lengths scaled by the division factor (minus one: countdown to zero)
  always_comb begin
    fdf_w      = CNT_W'(fdf_of(cfg_prsc));
    sample_len = SMP_U * fdf_w - CNT_W'(1);
    hold_len   = HLD_U * fdf_w - CNT_W'(1);
  end

  assign abort   = cfg_pdown | sw_start_clr;
  assign ch_done = (phase_q == PH_CONVERT) && tmr_done && !abort;
  assign at_last = (ch_q == LAST_CH);
  assign wrap    = ch_done && at_last && cfg_cont;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = sample_len;
    if (!abort) begin
      unique case (phase_q)
        PH_IDLE:    tmr_load = start_q;
        PH_SAMPLE:  begin
                      tmr_load = tmr_done;
                      tmr_val  = hold_len;
                    end
        PH_CONVERT: tmr_load = tmr_done && (!at_last || cfg_cont);
        default:    tmr_load = 1'b0;
      endcase
    end
  end

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  // Scan control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ch_q    <= '0;
      start_q <= 1'b0;
    end else if (abort) begin
      phase_q <= PH_IDLE;
      start_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_q) begin
            phase_q <= PH_SAMPLE;
            ch_q    <= cfg_first_ch;
          end else if (sw_start_set || trig_evt) begin
            start_q <= 1'b1;
          end
        end
        PH_SAMPLE: begin
          if (tmr_done) phase_q <= PH_CONVERT;
        end
        PH_CONVERT: begin
          if (tmr_done) begin
            if (!at_last) begin
              ch_q    <= ch_q + CH_W'(1);
              phase_q <= PH_SAMPLE;
            end else if (wrap) begin
              ch_q    <= cfg_first_ch;
              phase_q <= PH_SAMPLE;
            end else begin
              phase_q <= PH_IDLE;
              start_q <= 1'b0;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // End-of-scan flag: a new completion wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    eoc_q <= 1'b0;
    else if (ch_done && at_last)   eoc_q <= 1'b1;
    else if (eoc_clr)              eoc_q <= 1'b0;
  end

  adc_result_bank #(.CH_N(CH_N), .RES_W(RES_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ch_done),
    .wr_ch   (ch_q),
    .wr_data (conv_result),
    .rd_ch   (rd_sel),
    .rd_data (rd_data)
  );

  assign conv_ch      = ch_q;
  assign conv_sample  = (phase_q == PH_SAMPLE);
  assign conv_convert = (phase_q == PH_CONVERT);
  assign busy         = (phase_q != PH_IDLE);
  assign start_bit    = start_q;
  assign eoc_flag     = eoc_q;
  assign eoc_irq      = eoc_q & cfg_eoc_en;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_N  = 8,
  localparam int CH_W = $clog2(CH_N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_cont,
  input logic [CH_W-1:0] cfg_first_ch,
  input logic            cfg_pdown,
  input logic            sw_start_clr,
  input logic [CH_W-1:0] conv_ch,
  input logic            conv_sample,
  input logic            conv_convert,
  input logic            busy,
  input logic            start_bit,
  input logic            eoc_flag
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(CH_N - 1);

  assert_ch_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && conv_ch != $past(conv_ch)) |->
      (conv_ch == $past(conv_ch) + CH_W'(1)) || (conv_ch == $past(cfg_first_ch)));

  assert_scan_begins_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> conv_ch == $past(cfg_first_ch));

  assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> start_bit);

  assert_start_drop_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_bit) |-> ($past(sw_start_clr) || $past(cfg_pdown) ||
      (!$past(cfg_cont) && $past(conv_ch) == LAST_CH && $past(conv_convert))));

  assert_phase_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_sample, conv_convert}));

  assert_pdown_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pdown |=> (!busy && !start_bit));

  assert_eoc_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_flag) |-> ($past(conv_ch) == LAST_CH && $past(conv_convert)));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_N(CH_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_cont     (cfg_cont),
  .cfg_first_ch (cfg_first_ch),
  .cfg_pdown    (cfg_pdown),
  .sw_start_clr (sw_start_clr),
  .conv_ch      (conv_ch),
  .conv_sample  (conv_sample),
  .conv_convert (conv_convert),
  .busy         (busy),
  .start_bit    (start_bit),
  .eoc_flag     (eoc_flag)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;

  localparam int CH_N  = 8;
  localparam int RES_W = 10;
  localparam int CH_W  = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_cont, cfg_pdown, cfg_ext_en, cfg_tim_en, cfg_eoc_en;
  logic [CH_W-1:0]  cfg_first_ch;
  logic [2:0]       cfg_prsc;
  logic             sw_start_set, sw_start_clr, eoc_clr;
  logic             ext_trig_n, tim_trig_n;
  logic [RES_W-1:0] conv_result;
  logic [CH_W-1:0]  conv_ch;
  logic             conv_sample, conv_convert, busy, start_bit, eoc_flag, eoc_irq;
  logic [CH_W-1:0]  rd_sel;
  logic [RES_W-1:0] rd_data;

  logic [RES_W-1:0] src_val [CH_N];
  logic [RES_W-1:0] exp_reg [CH_N];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  // Converter model: result depends on the channel being converted
  always_comb conv_result = src_val[conv_ch];

  adc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_cont(cfg_cont), .cfg_first_ch(cfg_first_ch),
    .cfg_prsc(cfg_prsc), .cfg_pdown(cfg_pdown), .cfg_ext_en(cfg_ext_en),
    .cfg_tim_en(cfg_tim_en), .cfg_eoc_en(cfg_eoc_en), .sw_start_set(sw_start_set),
    .sw_start_clr(sw_start_clr), .eoc_clr(eoc_clr), .ext_trig_n(ext_trig_n),
    .tim_trig_n(tim_trig_n), .conv_result(conv_result), .conv_ch(conv_ch),
    .conv_sample(conv_sample), .conv_convert(conv_convert), .busy(busy),
    .start_bit(start_bit), .eoc_flag(eoc_flag), .eoc_irq(eoc_irq),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic int fdf_exp(input int code);
    int t [8] = '{1, 2, 4, 6, 8, 10, 12, 16};
    return t[code];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input int ch, input string tag);
    rd_sel = CH_W'(ch);
    #1;
    chk(tag, 32'(rd_data), 32'(exp_reg[ch]));
  endtask

  task automatic all_regs(input string tag);
    for (int c = 0; c < CH_N; c++) rd_chk(c, tag);
    @(negedge clk);
  endtask

  task automatic clear_eoc();
    eoc_clr = 1'b1; wait_n(1); eoc_clr = 1'b0;
    chk("R11 flag cleared by eoc_clr", 32'(eoc_flag), 0);
  endtask

  task automatic run_single(input int first, input int prsc, input bit irq_en);
    int f = fdf_exp(prsc);
    int k = CH_N - 1 - first;
    cfg_cont = 1'b0; cfg_first_ch = CH_W'(first); cfg_prsc = 3'(prsc); cfg_eoc_en = irq_en;
    for (int c = 0; c < CH_N; c++) src_val[c] = RES_W'($urandom);
    clear_eoc();
    sw_start_set = 1'b1; wait_n(1); sw_start_set = 1'b0;
    chk("R3 start bit after request", 32'(start_bit), 1);
    chk("R3 not busy yet", 32'(busy), 0);
    wait_n(1);
    chk("R3 busy one edge later", 32'(busy), 1);
    chk("R2 first channel", 32'(conv_ch), 32'(first));
    chk("R9 sample phase begins", 32'(conv_sample), 1);
    wait_n(84 * f - 1);
    chk("R9 last sample cycle", 32'(conv_sample), 1);
    wait_n(1);
    chk("R9 convert after 84*FDF", 32'(conv_convert), 1);
    wait_n(54 * f - 1);
    chk("R9 last convert cycle", 32'(conv_convert), 1);
    rd_chk(first, "R6 not yet written");
    wait_n(1);
    exp_reg[first] = src_val[first];
    rd_chk(first, "R6 written at end of convert");
    if (k > 0) begin
      chk("R1 channel steps by one", 32'(conv_ch), 32'(first + 1));
      chk("R11 no flag before last", 32'(eoc_flag), 0);
    end
    wait_n(138 * f * k);
    chk("R11 flag after last channel", 32'(eoc_flag), 1);
    chk("R11 irq follows mask", 32'(eoc_irq), 32'(irq_en));
    chk("R4 single mode start cleared", 32'(start_bit), 0);
    chk("R4 single mode idle", 32'(busy), 0);
    for (int c = first; c < CH_N; c++) exp_reg[c] = src_val[c];
    all_regs("R6 result bank after scan");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_cont = 0; cfg_pdown = 0; cfg_ext_en = 0; cfg_tim_en = 0;
    cfg_eoc_en = 0; cfg_first_ch = '0; cfg_prsc = '0; sw_start_set = 0;
    sw_start_clr = 0; eoc_clr = 0; ext_trig_n = 1; tim_trig_n = 1; rd_sel = '0;
    for (int c = 0; c < CH_N; c++) begin src_val[c] = '0; exp_reg[c] = '0; end
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R3 reset start bit", 32'(start_bit), 0);
    chk("R3 reset busy", 32'(busy), 0);
    chk("R11 reset flag", 32'(eoc_flag), 0);
    all_regs("R6 reset registers");

    // Directed corners
    run_single(7, 4, 1'b1);   // only channel 7, FDF 8
    run_single(0, 0, 1'b0);   // full group, FDF 1

    // Constrained random single scans
    for (int i = 0; i < 5; i++)
      run_single(int'($urandom % 8), int'($urandom % 4), 1'(($urandom % 2)));

    // Continuous mode, first channel 5, FDF 1
    cfg_cont = 1'b1; cfg_first_ch = 3'd5; cfg_prsc = 3'd0; cfg_ext_en = 1'b1;
    for (int c = 0; c < CH_N; c++) src_val[c] = RES_W'($urandom);
    clear_eoc();
    sw_start_set = 1'b1; wait_n(1); sw_start_set = 1'b0;
    wait_n(1);
    chk("R2 continuous first channel", 32'(conv_ch), 5);
    wait_n(148);
    ext_trig_n = 1'b0; wait_n(1); ext_trig_n = 1'b1;
    wait_n(5);
    chk("R8 trigger during scan ignored", 32'(conv_ch), 6);
    chk("R8 still sampling", 32'(conv_sample), 1);
    wait_n(260);
    chk("R5 wrapped to first channel", 32'(conv_ch), 5);
    chk("R5 sample phase after wrap", 32'(conv_sample), 1);
    chk("R5 start bit kept", 32'(start_bit), 1);
    chk("R11 flag in continuous mode", 32'(eoc_flag), 1);
    for (int c = 5; c < CH_N; c++) exp_reg[c] = src_val[c];
    rd_chk(7, "R6 continuous last result");
    eoc_clr = 1'b1; wait_n(1); eoc_clr = 1'b0;
    chk("R11 flag cleared while running", 32'(eoc_flag), 0);
    sw_start_clr = 1'b1; wait_n(1); sw_start_clr = 1'b0;
    chk("R4 software clear stops start", 32'(start_bit), 0);
    chk("R4 software clear stops scan", 32'(busy), 0);
    cfg_ext_en = 1'b0;

    // Timer trigger enabled: start on third edge
    cfg_cont = 1'b0; cfg_tim_en = 1'b1;
    tim_trig_n = 1'b0; wait_n(1); tim_trig_n = 1'b1;
    wait_n(1);
    chk("R7 no start after two edges", 32'(start_bit), 0);
    wait_n(1);
    chk("R7 timer trigger sets start", 32'(start_bit), 1);
    sw_start_clr = 1'b1; wait_n(1); sw_start_clr = 1'b0;
    cfg_tim_en = 1'b0;

    // External trigger with its enable clear
    ext_trig_n = 1'b0; wait_n(1); ext_trig_n = 1'b1;
    wait_n(6);
    chk("R7 disabled trigger ignored", 32'(start_bit), 0);
    chk("R7 disabled trigger no scan", 32'(busy), 0);

    // Power-down blocks a start and stops a running scan
    cfg_pdown = 1'b1;
    sw_start_set = 1'b1; wait_n(1); sw_start_set = 1'b0;
    wait_n(2);
    chk("R10 start blocked", 32'(start_bit), 0);
    chk("R10 idle", 32'(busy), 0);
    cfg_pdown = 1'b0;
    sw_start_set = 1'b1; wait_n(1); sw_start_set = 1'b0;
    wait_n(10);
    cfg_pdown = 1'b1; wait_n(1);
    chk("R10 power-down stops scan", 32'(busy), 0);
    chk("R10 power-down clears start", 32'(start_bit), 0);
    cfg_pdown = 1'b0;
    all_regs("R6 aborted scan leaves results");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule